// File: doc/BRIEF.md
# Ethernet Port Traffic Engine (Test Generator, Checker and Address-Swap Loopback)

This block sits on one Ethernet port, between the receive and transmit byte streams of a MAC. Each stream is 8 bits wide and uses valid/ready handshaking. One datapath serves two modes, and the `gen_en` input selects between them.

With `gen_en` low, the block works as a loopback. Every received frame is sent back out of the same port with its two 6-byte MAC address fields exchanged. With `gen_en` high, the block transmits fixed-format test frames back to back. When `chk_en` is also high, it judges every received frame against that same format.

The block reports errors through a sticky flag and a saturating counter, and `err_clr` clears both. An activity output shows handshake traffic in either direction. A bring-up harness drives the two mode inputs from static settings. It reads the status outputs to confirm that a link carries error-free traffic, or that a remote station sees its frames echoed.

Top module: `eth_traffic_engine`

## Requirements
- R1: With the loopback mode in force, every received frame of at least 12 bytes is retransmitted with the same length. Output bytes 0-5 equal input bytes 6-11, output bytes 6-11 equal input bytes 0-5, and all later bytes are unchanged. `tx_tlast` is asserted on the final byte only.
- R2: While `tx_tvalid` is high and `tx_tready` is low, `tx_tdata` and `tx_tlast` hold steady and `tx_tvalid` stays high. Under any pattern of transmit stalls, no byte is lost or duplicated.
- R3: In loopback, a received frame whose `rx_tlast` comes before its 12th byte is discarded, and nothing is transmitted for it. A frame of exactly 12 bytes is echoed as 12 swapped bytes.
- R4: In generate mode, frames of 14+PAYLOAD_LEN bytes are sent with `tx_tvalid` held high between them. Byte n has this layout:
  - n = 0..5: DST_MAC, most significant byte first.
  - n = 6..11: SRC_MAC, most significant byte first.
  - n = 12..13: PAYLOAD_LEN as a 16-bit value, most significant byte first.
  - n ≥ 14: the value (n-14) modulo 256.
- R5: A change of `gen_en` takes effect only at a transmit frame boundary. A frame already started is completed, and the other mode starts with a new frame.
- R6: In generate mode, a received frame whose final byte is accepted while `chk_en` is high is judged against the R4 layout. A frame with any differing byte adds exactly one to `err_count` and sets `err_flag`. A matching frame changes neither.
- R7: A judged frame that is shorter or longer than 14+PAYLOAD_LEN bytes counts as exactly one error. The next frame is judged from byte 0.
- R8: A frame whose final byte is accepted while `chk_en` is low never changes `err_count` or `err_flag`.
- R9: A cycle with `err_clr` high sets `err_count` to 0 and `err_flag` to 0 from the next cycle on. It does not interrupt transmitted traffic.
- R10: `err_count` stops at 2^ERR_W-1 instead of wrapping.
- R11: `activity` is high in the cycle after a byte is accepted on either stream and low in the cycle after a cycle with no accepted byte.
- R12: In generate mode, `rx_tready` is held high so that received frames are always consumed.
- R13: If a mode change lands while a received frame is partly accepted, the rest of that frame up to its `rx_tlast` is consumed and dropped. It is neither echoed nor judged.
- R14: During reset, `tx_tvalid`, `err_flag`, `err_count` and `activity` are all 0, and the block starts in loopback mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | 1 selects test-frame generation, 0 selects address-swap loopback |
| chk_en | input | 1 | Enables judging of received frames in generate mode |
| err_clr | input | 1 | Clears error count and error flag |
| rx_tdata | input | 8 | Received byte |
| rx_tvalid | input | 1 | Received byte valid |
| rx_tlast | input | 1 | Received byte is the last of its frame |
| rx_tready | output | 1 | Block accepts a received byte |
| tx_tdata | output | 8 | Transmitted byte |
| tx_tvalid | output | 1 | Transmitted byte valid |
| tx_tlast | output | 1 | Transmitted byte is the last of its frame |
| tx_tready | input | 1 | MAC accepts the transmitted byte |
| err_flag | output | 1 | Sticky frame-error indication |
| err_count | output | ERR_W | Saturating count of bad frames |
| activity | output | 1 | Traffic indicator, one cycle after an accepted byte |

## Verification
The hardest state to reach is a mode change that falls while a received frame is only partly accepted. The change has to wait for the end of the current transmit frame, and the received frame has to remain open across that wait.

The stimulus reaches this state in generate mode. It delivers the first bytes of a frame, pauses the receive stream, drops `gen_en` in the middle of a transmitted test frame, and resumes the receive stream only after the generator has stopped. The bench then confirms three things: the generator ended on a frame boundary, the rest of the frame vanished, and the next complete frame is echoed with its addresses swapped.

// File: rtl/eth_te_pkg.sv
package eth_te_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int HDR_BYTES  = 2 * ADDR_BYTES;
    localparam int HDR_CNT_W  = $clog2(HDR_BYTES + 1);

    typedef enum logic [1:0] {
        LB_COLLECT,
        LB_EMIT,
        LB_FWD
    } lb_state_e;

    typedef struct packed {
        logic       valid;
        logic       last;
        logic [7:0] data;
    } beat_t;

    // Byte n of a test frame: dst, src, length, counting payload
    function automatic logic [7:0] frame_byte(input logic [15:0] idx,
                                              input logic [47:0] dst,
                                              input logic [47:0] src,
                                              input logic [15:0] plen);
        logic [47:0] sh;
        logic [7:0]  r;
        if (idx < 16'(ADDR_BYTES)) begin
            sh = dst >> (8 * (ADDR_BYTES - 1 - int'(idx)));
            r  = sh[7:0];
        end else if (idx < 16'(HDR_BYTES)) begin
            sh = src >> (8 * (HDR_BYTES - 1 - int'(idx)));
            r  = sh[7:0];
        end else if (idx == 16'(HDR_BYTES)) begin
            r = plen[15:8];
        end else if (idx == 16'(HDR_BYTES + 1)) begin
            r = plen[7:0];
        end else begin
            r = 8'(idx - 16'(HDR_BYTES + 2));
        end
        return r;
    endfunction

    // Header slot that feeds output header position k (address exchange)
    function automatic logic [HDR_CNT_W-1:0] hdr_src_pos(input logic [HDR_CNT_W-1:0] k);
        return (k < HDR_CNT_W'(ADDR_BYTES)) ? k + HDR_CNT_W'(ADDR_BYTES)
                                            : k - HDR_CNT_W'(ADDR_BYTES);
    endfunction

endpackage

// File: rtl/eth_te_swap.sv
module eth_te_swap
    import eth_te_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic        rx_last,
    output logic        rx_ready,
    output beat_t       tx_beat,
    input  logic        tx_ready
);
    localparam logic [HDR_CNT_W-1:0] LAST_SLOT = HDR_CNT_W'(HDR_BYTES - 1);

    lb_state_e             state_q;
    logic [HDR_CNT_W-1:0]  cnt_q;
    logic                  hdr_last_q;
    logic [7:0]            hbuf_q [HDR_BYTES];
    logic                  rx_fire;
    logic                  tx_fire;

    always_comb begin
        tx_beat  = '0;
        rx_ready = 1'b0;
        if (en) begin
            unique case (state_q)
                LB_COLLECT: rx_ready = 1'b1;
                LB_EMIT: begin
                    tx_beat.valid = 1'b1;
                    tx_beat.data  = hbuf_q[hdr_src_pos(cnt_q)];
                    tx_beat.last  = hdr_last_q && (cnt_q == LAST_SLOT);
                end
                LB_FWD: begin
                    tx_beat.valid = rx_valid;
                    tx_beat.data  = rx_data;
                    tx_beat.last  = rx_last;
                    rx_ready      = tx_ready;
                end
                default: ;
            endcase
        end
    end

    assign rx_fire = rx_valid && rx_ready;
    assign tx_fire = tx_beat.valid && tx_ready;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q    <= LB_COLLECT;
            cnt_q      <= '0;
            hdr_last_q <= 1'b0;
        end else begin
            unique case (state_q)
                LB_COLLECT: if (rx_fire) begin
                    hbuf_q[cnt_q] <= rx_data;
                    if (cnt_q == LAST_SLOT) begin
                        state_q    <= LB_EMIT;
                        cnt_q      <= '0;
                        hdr_last_q <= rx_last;
                    end else if (rx_last) begin
                        cnt_q <= '0;          // runt frame: drop
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                LB_EMIT: if (tx_fire) begin
                    if (cnt_q == LAST_SLOT) begin
                        cnt_q   <= '0;
                        state_q <= hdr_last_q ? LB_COLLECT : LB_FWD;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                LB_FWD: if (tx_fire && rx_last) state_q <= LB_COLLECT;
                default: state_q <= LB_COLLECT;
            endcase
        end
    end
endmodule

// File: rtl/eth_te_check.sv
module eth_te_check
    import eth_te_pkg::*;
#(
    parameter int          FRAME_LEN   = 60,
    parameter int          PAYLOAD_LEN = 46,
    parameter logic [47:0] DST_MAC     = 48'h0,
    parameter logic [47:0] SRC_MAC     = 48'h0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       track,
    input  logic       beat,
    input  logic [7:0] data,
    input  logic       last,
    input  logic       judge,
    output logic       err_evt
);
    localparam int IDX_W = $clog2(FRAME_LEN + 1);

    logic [IDX_W-1:0] idx_q;
    logic             bad_q;
    logic             over;
    logic             mism;
    logic             len_bad;

    assign over    = (idx_q >= IDX_W'(FRAME_LEN));
    assign mism    = over || (data != frame_byte(16'(idx_q), DST_MAC, SRC_MAC, 16'(PAYLOAD_LEN)));
    assign len_bad = (idx_q != IDX_W'(FRAME_LEN - 1));
    assign err_evt = track && beat && last && judge && (bad_q || mism || len_bad);

    always_ff @(posedge clk) begin
        if (rst || !track) begin
            idx_q <= '0;
            bad_q <= 1'b0;
        end else if (beat) begin
            if (last) begin
                idx_q <= '0;
                bad_q <= 1'b0;
            end else begin
                idx_q <= over ? idx_q : idx_q + 1'b1;
                bad_q <= bad_q || mism;
            end
        end
    end
endmodule

// File: rtl/eth_te_status.sv
module eth_te_status #(
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err_evt,
    input  logic             err_clr,
    input  logic             rx_fire,
    input  logic             tx_fire,
    output logic             err_flag,
    output logic [ERR_W-1:0] err_count,
    output logic             activity
);
    localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag  <= 1'b0;
            err_count <= '0;
            activity  <= 1'b0;
        end else begin
            activity <= rx_fire || tx_fire;
            if (err_clr) begin
                err_flag  <= 1'b0;
                err_count <= '0;
            end else if (err_evt) begin
                err_flag <= 1'b1;
                if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/eth_traffic_engine.sv
module eth_traffic_engine
    import eth_te_pkg::*;
#(
    parameter int          PAYLOAD_LEN = 46,
    parameter int          ERR_W       = 16,
    parameter logic [47:0] DST_MAC     = 48'h02_11_22_33_44_55,
    parameter logic [47:0] SRC_MAC     = 48'h02_AA_BB_CC_DD_EE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_en,
    input  logic             chk_en,
    input  logic             err_clr,
    input  logic [7:0]       rx_tdata,
    input  logic             rx_tvalid,
    input  logic             rx_tlast,
    output logic             rx_tready,
    output logic [7:0]       tx_tdata,
    output logic             tx_tvalid,
    output logic             tx_tlast,
    input  logic             tx_tready,
    output logic             err_flag,
    output logic [ERR_W-1:0] err_count,
    output logic             activity
);
    localparam int FRAME_LEN = HDR_BYTES + 2 + PAYLOAD_LEN;
    localparam int IDX_W     = $clog2(FRAME_LEN + 1);

    logic             mode_gen_q;
    logic             drain_q;
    logic             tx_mid_q, rx_mid_q;
    logic             tx_mid_n, rx_mid_n;
    logic [IDX_W-1:0] gen_idx_q;
    logic             rx_fire, tx_fire;
    logic             switch_ok, mode_chg;
    logic             lb_en, lb_rx_ready;
    logic             err_evt;
    beat_t            gen_beat, lb_beat, tx_sel;

    // generator beat
    always_comb begin
        gen_beat.valid = mode_gen_q;
        gen_beat.data  = frame_byte(16'(gen_idx_q), DST_MAC, SRC_MAC, 16'(PAYLOAD_LEN));
        gen_beat.last  = (gen_idx_q == IDX_W'(FRAME_LEN - 1));
    end

    assign tx_sel    = mode_gen_q ? gen_beat : lb_beat;
    assign tx_tdata  = tx_sel.data;
    assign tx_tvalid = tx_sel.valid;
    assign tx_tlast  = tx_sel.last;

    assign lb_en     = !mode_gen_q && !drain_q;
    assign rx_tready = (mode_gen_q || drain_q) ? 1'b1 : lb_rx_ready;

    assign rx_fire   = rx_tvalid && rx_tready;
    assign tx_fire   = tx_tvalid && tx_tready;
    assign rx_mid_n  = rx_fire ? !rx_tlast : rx_mid_q;
    assign tx_mid_n  = tx_fire ? !tx_tlast : tx_mid_q;

    // a frame boundary on the transmit side: nothing started, nothing pending
    assign switch_ok = !tx_mid_n && !(tx_tvalid && !tx_tready);
    assign mode_chg  = switch_ok && (gen_en != mode_gen_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_gen_q <= 1'b0;
            drain_q    <= 1'b0;
            tx_mid_q   <= 1'b0;
            rx_mid_q   <= 1'b0;
            gen_idx_q  <= '0;
        end else begin
            tx_mid_q <= tx_mid_n;
            rx_mid_q <= rx_mid_n;
            if (mode_chg) begin
                mode_gen_q <= gen_en;
                drain_q    <= rx_mid_n;
            end else if (drain_q && rx_fire && rx_tlast) begin
                drain_q <= 1'b0;
            end
            if (mode_gen_q && tx_fire)
                gen_idx_q <= gen_beat.last ? '0 : gen_idx_q + 1'b1;
        end
    end

    eth_te_swap u_swap (
        .clk      (clk),
        .rst      (rst),
        .en       (lb_en),
        .rx_data  (rx_tdata),
        .rx_valid (rx_tvalid),
        .rx_last  (rx_tlast),
        .rx_ready (lb_rx_ready),
        .tx_beat  (lb_beat),
        .tx_ready (tx_tready)
    );

    eth_te_check #(
        .FRAME_LEN   (FRAME_LEN),
        .PAYLOAD_LEN (PAYLOAD_LEN),
        .DST_MAC     (DST_MAC),
        .SRC_MAC     (SRC_MAC)
    ) u_check (
        .clk     (clk),
        .rst     (rst),
        .track   (mode_gen_q && !drain_q),
        .beat    (rx_fire),
        .data    (rx_tdata),
        .last    (rx_tlast),
        .judge   (chk_en),
        .err_evt (err_evt)
    );

    eth_te_status #(.ERR_W(ERR_W)) u_status (
        .clk       (clk),
        .rst       (rst),
        .err_evt   (err_evt),
        .err_clr   (err_clr),
        .rx_fire   (rx_fire),
        .tx_fire   (tx_fire),
        .err_flag  (err_flag),
        .err_count (err_count),
        .activity  (activity)
    );
endmodule

// File: rtl/eth_te_sva.sv
module eth_te_sva #(
    parameter int ERR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_tvalid,
    input logic             rx_tready,
    input logic [7:0]       tx_tdata,
    input logic             tx_tvalid,
    input logic             tx_tlast,
    input logic             tx_tready,
    input logic             err_clr,
    input logic             err_flag,
    input logic [ERR_W-1:0] err_count,
    input logic             activity
);
    localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_tvalid && !tx_tready) |=> (tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast)));

    // R9
    err_clr_chk: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> (err_count == '0 && !err_flag));

    // R10
    err_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (err_count == CNT_MAX && !err_clr) |=> (err_count == CNT_MAX));

    // R6
    err_step_chk: assert property (@(posedge clk) disable iff (rst)
        !err_clr |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

    // R6
    flag_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (err_count != '0) |-> err_flag);

    // R11
    act_on_chk: assert property (@(posedge clk) disable iff (rst)
        ((rx_tvalid && rx_tready) || (tx_tvalid && tx_tready)) |=> activity);

    // R11
    act_off_chk: assert property (@(posedge clk) disable iff (rst)
        !((rx_tvalid && rx_tready) || (tx_tvalid && tx_tready)) |=> !activity);
endmodule

bind eth_traffic_engine eth_te_sva #(.ERR_W(ERR_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .rx_tvalid (rx_tvalid),
    .rx_tready (rx_tready),
    .tx_tdata  (tx_tdata),
    .tx_tvalid (tx_tvalid),
    .tx_tlast  (tx_tlast),
    .tx_tready (tx_tready),
    .err_clr   (err_clr),
    .err_flag  (err_flag),
    .err_count (err_count),
    .activity  (activity)
);

// File: tb/sim_eth_traffic_engine.sv
module sim_eth_traffic_engine;
    localparam int          PL    = 6;
    localparam int          FL    = 14 + PL;
    localparam int          EW    = 3;
    localparam logic [47:0] DA    = 48'h02_11_22_33_44_55;
    localparam logic [47:0] SA    = 48'h02_AA_BB_CC_DD_EE;

    // entry: [31:24] length, [23:16] corrupted index (FF none), [15:8] chk_en, [7:0] expected error increment
    localparam logic [31:0] VEC [11] = '{
        32'h14_FF_01_00, 32'h14_03_01_01, 32'h14_0D_01_01, 32'h14_13_01_01,
        32'h13_FF_01_01, 32'h19_FF_01_01, 32'h01_FF_01_01, 32'h14_0A_00_00,
        32'h19_FF_00_00, 32'h14_08_01_01, 32'h14_FF_01_00
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          gen_en = 1'b0, chk_en = 1'b0, err_clr = 1'b0;
    logic [7:0]    rx_tdata = '0;
    logic          rx_tvalid = 1'b0, rx_tlast = 1'b0;
    logic          rx_tready;
    logic [7:0]    tx_tdata;
    logic          tx_tvalid, tx_tlast;
    logic          tx_tready = 1'b0;
    logic          err_flag;
    logic [EW-1:0] err_count;
    logic          activity;

    int            n_chk = 0, n_fail = 0;
    int            stall_mode = 0;
    int            cyc = 0;
    int            tx_gap = 0, rx_stall = 0;
    logic          tx_seen = 1'b0, saw_last = 1'b0;
    logic [8:0]    txq [$];
    logic [7:0]    fbuf [64];

    always #4 clk = ~clk;

    eth_traffic_engine #(.PAYLOAD_LEN(PL), .ERR_W(EW), .DST_MAC(DA), .SRC_MAC(SA)) u0 (
        .clk(clk), .rst(rst), .gen_en(gen_en), .chk_en(chk_en), .err_clr(err_clr),
        .rx_tdata(rx_tdata), .rx_tvalid(rx_tvalid), .rx_tlast(rx_tlast), .rx_tready(rx_tready),
        .tx_tdata(tx_tdata), .tx_tvalid(tx_tvalid), .tx_tlast(tx_tlast), .tx_tready(tx_tready),
        .err_flag(err_flag), .err_count(err_count), .activity(activity));

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // transmit-side sink: drives tx_tready and records accepted beats
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            case (stall_mode)
                1:       tx_tready = cyc[0];
                2:       tx_tready = (cyc % 3) == 0;
                default: tx_tready = 1'b1;
            endcase
            #2;
            if (tx_tvalid && tx_tready) begin
                txq.push_back({tx_tlast, tx_tdata});
                tx_seen = 1'b1;
                if (tx_tlast) saw_last = 1'b1;
            end else if (tx_seen && !tx_tvalid) begin
                tx_gap++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        report();
    end

    function automatic logic [7:0] exp_byte(input int i);
        logic [47:0] s;
        if (i < 6)  begin s = DA >> (8 * (5 - i));  return s[7:0]; end
        if (i < 12) begin s = SA >> (8 * (11 - i)); return s[7:0]; end
        if (i == 12) return 8'(PL >> 8);
        if (i == 13) return 8'(PL);
        return 8'(i - 14);
    endfunction

    task automatic clear_tx();
        txq.delete();
        tx_seen = 1'b0;
        tx_gap  = 0;
    endtask

    task automatic rx_send(input int first, input int n, input bit with_last);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_tvalid = 1'b1;
            rx_tdata  = fbuf[first + i];
            rx_tlast  = with_last && (i == n - 1);
            #2;
            while (!rx_tready) begin
                rx_stall++;
                @(negedge clk);
                #2;
            end
        end
        @(negedge clk);
        rx_tvalid = 1'b0;
        rx_tlast  = 1'b0;
    endtask

    task automatic wait_txq(input int n, input int max_cyc);
        for (int i = 0; i < max_cyc && txq.size() < n; i++) @(negedge clk);
    endtask

    task automatic cmp_loop(input int n, input string req);
        int mism = 0;
        chk(txq.size() == n, req, "echo length", txq.size(), n);
        for (int k = 0; k < n && k < txq.size(); k++) begin
            logic [7:0] e;
            e = (k < 12) ? fbuf[(k < 6) ? k + 6 : k - 6] : fbuf[k];
            if (txq[k] != {(k == n - 1), e}) mism++;
        end
        chk(mism == 0, req, "echo byte mismatches", mism, 0);
    endtask

    initial begin
        // ---- reset state (R14)
        repeat (4) @(negedge clk);
        #2;
        chk(tx_tvalid == 1'b0, "R14", "tx_tvalid in reset", tx_tvalid, 0);
        chk(err_count == '0, "R14", "err_count in reset", err_count, 0);
        chk(err_flag == 1'b0, "R14", "err_flag in reset", err_flag, 0);
        chk(activity == 1'b0, "R14", "activity in reset", activity, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        chk(tx_tvalid == 1'b0, "R14", "loopback idle after reset", tx_tvalid, 0);
        chk(activity == 1'b0, "R11", "activity with no traffic", activity, 0);

        // ---- loopback (R1)
        for (int i = 0; i < 20; i++) fbuf[i] = 8'(8'h10 + i * 7);
        clear_tx();
        rx_send(0, 20, 1);
        wait_txq(20, 100);
        cmp_loop(20, "R1");

        // ---- loopback under transmit stalls (R2)
        stall_mode = 1;
        for (int i = 0; i < 30; i++) fbuf[i] = 8'(8'hA0 ^ (i * 13));
        clear_tx();
        rx_send(0, 30, 1);
        wait_txq(30, 200);
        cmp_loop(30, "R2");
        stall_mode = 2;
        for (int i = 0; i < 16; i++) fbuf[i] = 8'(8'h33 + i);
        clear_tx();
        rx_send(0, 16, 1);
        wait_txq(16, 200);
        cmp_loop(16, "R2");
        stall_mode = 0;

        // ---- runt and minimum frames (R3)
        clear_tx();
        rx_send(0, 8, 1);
        repeat (30) @(negedge clk);
        chk(txq.size() == 0, "R3", "runt frame beats sent", txq.size(), 0);
        clear_tx();
        rx_send(0, 12, 1);
        wait_txq(12, 60);
        cmp_loop(12, "R3");

        // ---- generator (R4, R11)
        @(negedge clk);
        clear_tx();
        gen_en = 1'b1;
        repeat (3 * FL + 6) @(negedge clk);
        #2;
        chk(activity == 1'b1, "R11", "activity during generation", activity, 1);
        begin
            int mism = 0;
            chk(txq.size() >= 3 * FL, "R4", "generated beat count", txq.size(), 3 * FL);
            for (int k = 0; k < 3 * FL && k < txq.size(); k++)
                if (txq[k] != {((k % FL) == FL - 1), exp_byte(k % FL)}) mism++;
            chk(mism == 0, "R4", "generated byte mismatches", mism, 0);
            chk(tx_gap == 0, "R4", "idle cycles between frames", tx_gap, 0);
        end

        // ---- checker vector table (R6, R7, R8, R12)
        rx_stall = 0;
        for (int v = 0; v < 11; v++) begin
            int len, cor, inc, c0;
            string req;
            len = int'(VEC[v][31:24]);
            cor = int'(VEC[v][23:16]);
            inc = int'(VEC[v][7:0]);
            req = (VEC[v][15:8] == 8'h00) ? "R8" : (len != FL) ? "R7" : "R6";
            @(negedge clk);
            chk_en = VEC[v][8];
            c0 = int'(err_count);
            for (int i = 0; i < len; i++) fbuf[i] = exp_byte(i) ^ ((i == cor) ? 8'h5A : 8'h00);
            rx_send(0, len, 1);
            repeat (3) @(negedge clk);
            #2;
            chk(int'(err_count) == c0 + inc, req, "error count after frame", err_count, c0 + inc);
            chk(err_flag == (c0 + inc != 0), req, "error flag after frame", err_flag, int'(c0 + inc != 0));
        end
        chk(rx_stall == 0, "R12", "rx_tready low cycles in generate mode", rx_stall, 0);

        // ---- clear (R9)
        @(negedge clk);
        clear_tx();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        repeat (2) @(negedge clk);
        #2;
        chk(err_count == '0, "R9", "count after clear", err_count, 0);
        chk(err_flag == 1'b0, "R9", "flag after clear", err_flag, 0);
        chk(tx_gap == 0 && txq.size() >= 2, "R9", "tx traffic gaps over clear", tx_gap, 0);

        // ---- saturation (R10)
        chk_en = 1'b1;
        for (int f = 0; f < 9; f++) begin
            fbuf[0] = 8'h00;
            rx_send(0, 1, 1);
        end
        repeat (3) @(negedge clk);
        #2;
        chk(err_count == 3'd7, "R10", "saturated count", err_count, 7);
        chk(err_flag == 1'b1, "R10", "flag at saturation", err_flag, 1);

        // ---- mode change mid-frame and drain (R5, R13)
        @(negedge clk);
        chk_en = 1'b0;
        for (int i = 0; i < 20; i++) fbuf[i] = 8'(8'hC0 + i * 3);
        rx_send(0, 5, 0);
        clear_tx();
        saw_last = 1'b0;
        while (!saw_last) @(negedge clk);
        repeat (5) @(negedge clk);
        begin
            int n0, extra;
            n0 = txq.size();
            gen_en = 1'b0;
            repeat (3 * FL) @(negedge clk);
            #2;
            extra = txq.size() - n0;
            chk(tx_tvalid == 1'b0, "R5", "generator stopped", tx_tvalid, 0);
            chk(extra > 0 && extra < FL, "R5", "beats after gen_en fell", extra, FL - 5);
            chk(txq[txq.size() - 1][8] == 1'b1, "R5", "final beat carries tlast", txq[txq.size() - 1][8], 1);
        end
        clear_tx();
        rx_send(5, 15, 1);
        repeat (20) @(negedge clk);
        chk(txq.size() == 0, "R13", "beats echoed from drained frame", txq.size(), 0);
        clear_tx();
        rx_send(0, 20, 1);
        wait_txq(20, 100);
        cmp_loop(20, "R13");

        repeat (4) @(negedge clk);
        report();
    end
endmodule